// File: doc/BRIEF.md
# Push-Button Code Lock Controller

This block is a synchronous Moore state machine that opens a door for one clock cycle once a start button has been pressed and four coloured buttons have then been pressed in a fixed order: red, blue, green, red. It has a start button, three colour buttons (red, green, blue) and a separate "some colour button is down" line. All of these inputs are assumed to be clean and already synchronous to the clock. The code is fixed in the logic and cannot be changed at run time.

A colour press is registered only on the rising edge of the "some colour down" line, so holding a button for many cycles counts as one press. At that edge the colour lines are classified. A press is accepted only when exactly the expected colour is down and the other two are up. Any other press sends the machine back to idle. For this reason the guards leaving every state are mutually exclusive and together cover every input combination. Holding all the buttons down cannot walk the machine to the open state. The unlock output is decoded from the state register alone.

Top module: `button_code_lock`

## Requirements
- R1: A synchronous active-high reset puts the machine in the idle state with the unlock output at 0. A colour press held down across reset is not counted as a new press.
- R2: In idle the machine moves to the armed state on a cycle where the start button is 1 and stays idle otherwise. Colour presses made in idle are ignored.
- R3: From the armed state, the presses red, blue, green and red (each with only that colour line at 1) drive unlock to 1 in the cycle that follows the clock edge that samples the fourth press.
- R4: Unlock is 1 for exactly one cycle. The machine then returns to idle with no input needed.
- R5: While waiting for a colour, the state holds on any cycle without a new press. This includes colour lines that change while the press line is low, and a press line that stays high.
- R6: A new press in which the expected colour is not the only colour down sends the machine to idle. This covers a wrong single colour and a press with no colour line set.
- R7: A press with two or three colour lines at 1 never advances the machine. It returns to idle, so holding all buttons never opens the door.
- R8: A press is recognised only on the 0-to-1 change of the press line. A long press counts once, and changing the colour lines while the press line stays high makes no new press.
- R9: The start button has no effect outside the idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startBtn | input | 1 | Start button, level |
| anyPress | input | 1 | High while any colour button is held |
| redBtn | input | 1 | Red button level |
| greenBtn | input | 1 | Green button level |
| blueBtn | input | 1 | Blue button level |
| unlockDoor | output | 1 | One-cycle unlock pulse |

## Verification
Two functions can fall in the same cycle: advancing on the expected colour, and aborting on a press that is not exact. Both depend on the same press edge, so a press that carries the right colour together with other colours decides between them. The bench reaches each waiting depth and applies every combination of start, press and colour lines in one cycle. It then probes the state that results by replaying the rest of the code and then a full code. It judges unlock on every cycle against an expected state computed from the requirements, so an advance taken where an abort was due shows up as an unlock at the wrong time.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int NUM_COLOURS = 3;
  localparam int COL_W = $clog2(NUM_COLOURS);

  typedef logic [COL_W-1:0] colour_idx_t;

  // Colour line positions in the packed colour vector.
  localparam colour_idx_t COL_RED   = colour_idx_t'(0);
  localparam colour_idx_t COL_GREEN = colour_idx_t'(1);
  localparam colour_idx_t COL_BLUE  = colour_idx_t'(2);

  // Encoding order matters: the waiting states advance by increment.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_GOT1  = 3'd2,
    ST_GOT2  = 3'd3,
    ST_GOT3  = 3'd4,
    ST_OPEN  = 3'd5
  } lock_state_e;

  typedef struct packed {
    logic                   press;
    logic [NUM_COLOURS-1:0] exact;
  } press_strobe_t;

  function automatic colour_idx_t expectedColour(lock_state_e s);
    case (s)
      ST_ARMED: return COL_RED;
      ST_GOT1:  return COL_BLUE;
      ST_GOT2:  return COL_GREEN;
      ST_GOT3:  return COL_RED;
      default:  return COL_RED;
    endcase
  endfunction

endpackage

// File: rtl/lock_press_dp.sv
module lock_press_dp
  import lock_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   anyPress,
  input  logic [NUM_COLOURS-1:0] colours,
  output press_strobe_t          strobes
);

  localparam logic [NUM_COLOURS-1:0] ONE = NUM_COLOURS'(1);

  logic pressPrev;
  logic pressEdge;

  // Reset to 1 so a press held through reset is not seen as new.
  always_ff @(posedge clk) begin
    if (rst) pressPrev <= 1'b1;
    else     pressPrev <= anyPress;
  end

  assign pressEdge     = anyPress & ~pressPrev;
  assign strobes.press = pressEdge;

  for (genvar i = 0; i < NUM_COLOURS; i++) begin : g_exact
    assign strobes.exact[i] = pressEdge && (colours == (ONE << i));
  end

  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    strobes.press |-> !$past(anyPress)); // R8

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          startBtn,
  input  press_strobe_t strobes,
  output lock_state_e   state,
  output logic          unlock
);

  lock_state_e stateNext;
  colour_idx_t expIdx;
  logic        inWaitColour;
  logic        hitExpected;

  assign expIdx       = expectedColour(state);
  assign inWaitColour = (state == ST_ARMED) || (state == ST_GOT1) ||
                        (state == ST_GOT2)  || (state == ST_GOT3);
  assign hitExpected  = strobes.exact[expIdx];

  // Guards per waiting state: !press | press&exact | press&!exact,
  // pairwise disjoint and jointly complete.
  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  stateNext = startBtn ? ST_ARMED : ST_IDLE;
      ST_ARMED, ST_GOT1, ST_GOT2, ST_GOT3: begin
        if (!strobes.press)   stateNext = state;
        else if (hitExpected) stateNext = lock_state_e'(state + 3'd1);
        else                  stateNext = ST_IDLE;
      end
      ST_OPEN:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign unlock = (state == ST_OPEN);

  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !startBtn) |=> state == ST_IDLE); // R2
  AST_IDLE_GO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startBtn) |=> state == ST_ARMED); // R2
  AST_NO_PRESS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inWaitColour && !strobes.press) |=> $stable(state)); // R5
  AST_MISS_ABORT: assert property (@(posedge clk) disable iff (rst)
    (inWaitColour && strobes.press && !hitExpected) |=> state == ST_IDLE); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    unlock |=> (!unlock && state == ST_IDLE)); // R4
  AST_OPEN_PATH: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> $past(state) == ST_GOT3); // R3

endmodule

// File: rtl/button_code_lock.sv
module button_code_lock
  import lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic startBtn,
  input  logic anyPress,
  input  logic redBtn,
  input  logic greenBtn,
  input  logic blueBtn,
  output logic unlockDoor
);

  logic [NUM_COLOURS-1:0] colourVec;
  press_strobe_t          strobes;
  lock_state_e            state;

  always_comb begin
    colourVec            = '0;
    colourVec[COL_RED]   = redBtn;
    colourVec[COL_GREEN] = greenBtn;
    colourVec[COL_BLUE]  = blueBtn;
  end

  lock_press_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .anyPress (anyPress),
    .colours  (colourVec),
    .strobes  (strobes)
  );

  lock_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startBtn (startBtn),
    .strobes  (strobes),
    .state    (state),
    .unlock   (unlockDoor)
  );

  AST_MULTI_NEVER_OPENS: assert property (@(posedge clk) disable iff (rst)
    (strobes.press && $countones(colourVec) > 1) |=> !unlockDoor); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_OPEN && !strobes.press) |=> $stable(state)); // R9

endmodule

// File: tb/sim_button_code_lock.sv
`timescale 1ns/1ps
module sim_button_code_lock;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startBtn = 1'b0, anyPress = 1'b0;
  logic redBtn = 1'b0, greenBtn = 1'b0, blueBtn = 1'b0;
  logic unlockDoor;

  int checks = 0;
  int failures = 0;
  int mState = 0;     // 0 idle,1 armed,2..4 after 1..3 colours,5 open
  logic mPrevA = 1'b1;

  always #4 clk = ~clk;

  button_code_lock u0 (
    .clk(clk), .rst(rst), .startBtn(startBtn), .anyPress(anyPress),
    .redBtn(redBtn), .greenBtn(greenBtn), .blueBtn(blueBtn),
    .unlockDoor(unlockDoor)
  );

  // Colour masks: bit0 red, bit1 green, bit2 blue.
  function automatic logic [2:0] codeMask(int k);
    case (k)
      0: return 3'b001;
      1: return 3'b100;
      2: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

  function automatic int modelNext(int s, logic st, logic a, logic pa, logic [2:0] m);
    if (s == 0) return st ? 1 : 0;
    if (s == 5) return 0;
    if (!(a && !pa)) return s;
    if (m == codeMask(s - 1)) return s + 1;
    return 0;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s unlock=%0b expected=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic [2:0] m, input string tag);
    int nxt;
    @(negedge clk);
    startBtn = s; anyPress = a;
    {blueBtn, greenBtn, redBtn} = m;
    nxt = modelNext(mState, s, a, mPrevA, m);
    @(posedge clk); #1;
    mState = nxt; mPrevA = a;
    check(unlockDoor, mState == 5, tag);
  endtask

  task automatic doReset(input logic holdA, input logic [2:0] m);
    @(negedge clk);
    rst = 1'b1; startBtn = 1'b0; anyPress = holdA;
    {blueBtn, greenBtn, redBtn} = m;
    @(posedge clk); #1;
    mState = 0; mPrevA = 1'b1;
    check(unlockDoor, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic press(input logic [2:0] m, input string tag);
    step(1'b0, 1'b1, m, tag);
    step(1'b0, 1'b0, 3'b000, tag);
  endtask

  task automatic fullCode(input string tag);
    step(1'b1, 1'b0, 3'b000, tag);
    step(1'b0, 1'b0, 3'b000, tag);
    for (int k = 0; k < 4; k++) press(codeMask(k), tag);
    step(1'b0, 1'b0, 3'b000, tag);
  endtask

  function automatic string comboTag(int d, logic st, logic a, logic [2:0] m);
    if (d == 0) return "R2";
    if (!a) return st ? "R9" : "R5";
    if (m == codeMask(d - 1)) return "R3";
    if ($countones(m) > 1) return "R7";
    return "R6";
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    doReset(1'b0, 3'b000);
    check(unlockDoor, 1'b0, "R1");

    // R3/R4: plain correct entry, pulse length checked per cycle.
    fullCode("R3");
    step(1'b0, 1'b0, 3'b000, "R4");

    // R2: colour presses in idle are ignored, then the code still works.
    press(3'b001, "R2");
    press(3'b111, "R2");
    fullCode("R2");

    // R7: hold all buttons and mash them.
    step(1'b1, 1'b0, 3'b000, "R7");
    for (int k = 0; k < 6; k++) press(3'b111, "R7");
    step(1'b0, 1'b1, 3'b111, "R7");
    step(1'b0, 1'b1, 3'b111, "R7");

    // R8: long red press counts once; colour change under held press ignored.
    doReset(1'b0, 3'b000);
    step(1'b1, 1'b0, 3'b000, "R8");
    step(1'b0, 1'b1, 3'b001, "R8");
    step(1'b0, 1'b1, 3'b001, "R8");
    step(1'b0, 1'b1, 3'b100, "R8");
    step(1'b0, 1'b1, 3'b010, "R8");
    step(1'b0, 1'b0, 3'b000, "R8");
    press(3'b100, "R8");
    press(3'b010, "R8");
    press(3'b001, "R8");
    step(1'b0, 1'b0, 3'b000, "R8");

    // R1: press held through reset is not new.
    doReset(1'b1, 3'b001);
    step(1'b1, 1'b1, 3'b001, "R1");
    step(1'b0, 1'b1, 3'b001, "R1");
    step(1'b0, 1'b0, 3'b000, "R1");
    for (int k = 0; k < 4; k++) press(codeMask(k), "R1");
    step(1'b0, 1'b0, 3'b000, "R1");

    // Sweep: every single-cycle input combination at every waiting depth.
    for (int d = 0; d < 5; d++) begin
      for (int c = 0; c < 32; c++) begin
        logic st, a;
        logic [2:0] m;
        string tg;
        st = c[4]; a = c[3]; m = c[2:0];
        tg = comboTag(d, st, a, m);
        doReset(1'b0, 3'b000);
        if (d >= 1) begin
          step(1'b1, 1'b0, 3'b000, tg);
          step(1'b0, 1'b0, 3'b000, tg);
          for (int k = 0; k < d - 1; k++) press(codeMask(k), tg);
        end
        step(st, a, m, tg);
        step(1'b0, 1'b0, 3'b000, tg);
        if (d >= 1)
          for (int k = d - 1; k < 4; k++) press(codeMask(k), tg);
        step(1'b0, 1'b0, 3'b000, tg);
        fullCode(tg);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule